// File: doc/BRIEF.md
# Buffered BCD Clock Calendar Core

This block keeps wall-clock time in packed BCD: seconds, minutes, hours, date of month, month, day of week, two-digit year and century, plus one control byte. A one-second strobe advances the count. It carries across every field, uses the month length with a leap-day rule, and supports both 12-hour and 24-hour hour formats. The format is selected by a flag inside the hours byte itself.

Writes from the serial front end never touch the running counters directly. Each written byte is staged in a shadow buffer, with a per-byte "written" flag. When the frame ends, the front end reports whether the frame closed cleanly. On a clean close, every staged byte loads into the live counters in the same cycle. On a broken frame, the staged bytes are thrown away. A seconds strobe that arrives in the load cycle is dropped, so a freshly loaded value is never advanced early. The first strobe after the load advances it normally.

The block also holds seven alarm threshold bytes with fixed reset values. They are written directly. Matching against the time is not part of this block.

Top module: `rtcc_top`

## Requirements
- R1: After synchronous reset the live values are seconds 00h, minutes 00h, hours 00h, date 01h, month 01h, day of week 01h, year 70h, control 00h, century 19h.
- R2: The threshold bytes reset to 7Fh (seconds, thr_sel 0), 7Fh (minutes, 1), BFh (hours, 2), 3Fh (date, 3), 1Fh (month, 4), 07h (day of week, 5), FFh (year, 6). thr_o packs byte thr_sel=k at bits [8k+7:8k]. A write with thr_we_i replaces only the selected byte, and no byte changes without a write.
- R3: Seconds and minutes count in BCD, wrap 59h to 00h, and carry into the next field only on that wrap.
- R4: With hours bit 7 = 0 (24-hour), bits 5:0 hold BCD hours 00 to 23, so bit 5 is set for 20 to 23. Hour 23h wraps to 00h and carries into the date.
- R5: With hours bit 7 = 1 (12-hour), bit 5 is the PM flag (1 = PM) and bits 4:0 hold BCD 01 to 12. Hour 11 steps to 12 and toggles PM. Hour 12 steps to 01 with no toggle. A carry into the date happens only on 11 PM to 12 AM.
- R6: On a day carry, the date wraps to 01h after the last day of the month: 30 for months 04h, 06h, 09h and 11h; 29 for month 02h when the year is divisible by 4 (year 00h counts); 28 for other Februaries; 31 otherwise. Day of week counts 1 to 7 and wraps 07h to 01h on every day carry.
- R7: Month wraps 12h to 01h and carries into the year. Year wraps 99h to 00h and carries into the century.
- R8: Shadow writes (wr_en_i, wr_sel_i, wr_data_i) leave every live output unchanged, and the live counters keep advancing on ticks while bytes are staged. wr_sel_i codes: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 day of week, 6 year, 7 control, 8 century.
- R9: A clean frame end (frame_end_i and frame_ok_i high for one cycle) loads every byte staged since the last frame end into its live register on the next clock edge. Bytes that were not staged keep their live values.
- R10: A frame end with frame_ok_i low discards all staged bytes. The live values do not change, and a later clean frame end with nothing newly staged changes nothing.
- R11: A tick in the same cycle as a clean frame end is dropped entirely. The loaded value appears unadvanced and is advanced by the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle one-second strobe |
| wr_en_i | input | 1 | Shadow byte write strobe |
| wr_sel_i | input | 4 | Shadow byte select (codes in R8) |
| wr_data_i | input | 8 | Shadow byte data |
| frame_end_i | input | 1 | One-cycle pulse at end of a serial frame |
| frame_ok_i | input | 1 | Frame closed cleanly (valid with frame_end_i) |
| thr_we_i | input | 1 | Alarm threshold write strobe |
| thr_sel_i | input | 3 | Threshold byte select (codes in R2) |
| thr_data_i | input | 8 | Threshold byte data |
| sec_o | output | 8 | Live seconds (BCD) |
| min_o | output | 8 | Live minutes (BCD) |
| hour_o | output | 8 | Live hours with format and PM flags |
| date_o | output | 8 | Live date of month (BCD) |
| month_o | output | 8 | Live month (BCD) |
| dow_o | output | 8 | Live day of week (BCD 1 to 7) |
| year_o | output | 8 | Live year (BCD) |
| ctrl_o | output | 8 | Control byte |
| cent_o | output | 8 | Live century (BCD) |
| thr_o | output | 56 | Packed alarm threshold bytes |

## Verification
Counting is exercised from loaded edge points. One tick from 23:59:59 on 31 Dec 99 ripples through every field into the century. Loaded end-of-month points separate the leap February, the non-leap February and a 30-day month. Separate hour loads tell the 24-hour 19-to-20 step apart from the three 12-hour transitions (AM to PM, 12 to 01, PM to AM with a date carry). On the staging path, the bench distinguishes several cases: bytes staged while ticks continue, a full clean commit, an aborted frame followed by an empty commit, a partial commit of two bytes, and a commit that coincides with a tick.

// File: rtl/rtcc_pkg.sv
// Shared types and BCD helpers for the clock calendar core.
// Assumes all stored values are packed BCD bytes.
package rtcc_pkg;

    localparam int NREG   = 9;   // live / shadow bytes
    localparam int NTHR   = 7;   // alarm threshold bytes
    localparam int SEL_W  = 4;
    localparam int TSEL_W = 3;

    typedef logic [7:0] bcd_t;

    typedef enum logic [SEL_W-1:0] {
        IX_SEC  = 4'd0,
        IX_MIN  = 4'd1,
        IX_HOUR = 4'd2,
        IX_DATE = 4'd3,
        IX_MON  = 4'd4,
        IX_DOW  = 4'd5,
        IX_YEAR = 4'd6,
        IX_CTRL = 4'd7,
        IX_CENT = 4'd8
    } reg_ix_e;

    // Add one to a two-digit BCD value (no range wrap).
    function automatic bcd_t bcd_inc(bcd_t v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Year divisible by 4: tens parity and ones digit decide.
    function automatic logic is_leap(bcd_t yr);
        case (yr & 8'h1F)
            8'h00, 8'h04, 8'h08, 8'h12, 8'h16: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

    // Last valid date of a month.
    function automatic bcd_t month_last(bcd_t mon, bcd_t yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // One hour step: returns {day_carry, next_hour_byte}.
    function automatic logic [8:0] hour_step(bcd_t hr);
        bcd_t h;
        bcd_t flg;
        if (hr[7]) begin
            h   = hr & 8'h1F;
            flg = hr[5] ? 8'hA0 : 8'h80;
            if (h == 8'h12)      return {1'b0, 8'h01 | flg};
            else if (h == 8'h11) return {hr[5], 8'h12 | (hr[5] ? 8'h80 : 8'hA0)};
            else                 return {1'b0, bcd_inc(h) | flg};
        end else begin
            h = hr & 8'h3F;
            if (h == 8'h23) return {1'b1, 8'h00};
            return {1'b0, bcd_inc(h)};
        end
    endfunction

    function automatic bcd_t time_rst(int i);
        case (i)
            1, 2, 7: return 8'h00;
            6:       return 8'h70;
            8:       return 8'h19;
            0:       return 8'h00;
            default: return 8'h01;
        endcase
    endfunction

    function automatic bcd_t thr_rst(int i);
        case (i)
            0, 1:    return 8'h7F;
            2:       return 8'hBF;
            3:       return 8'h3F;
            4:       return 8'h1F;
            5:       return 8'h07;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/rtcc_shadow.sv
// Shadow buffer: stages written bytes with per-byte written flags.
// Flags clear at any frame end; load_o is raised only for a clean end.
module rtcc_shadow
    import rtcc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [SEL_W-1:0]           wr_sel_i,
    input  logic [7:0]                 wr_data_i,
    input  logic                       frame_end_i,
    input  logic                       frame_ok_i,
    output logic                       load_o,
    output logic [NREG-1:0]            mask_o,
    output logic [NREG-1:0][7:0]       data_o
);

    logic [NREG-1:0]      dirty_q;
    logic [NREG-1:0][7:0] buf_q;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        // Track whether this slot was written in the current frame.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 dirty_q[g] <= 1'b0;
            else if (frame_end_i)                       dirty_q[g] <= 1'b0;
            else if (wr_en_i && wr_sel_i == SEL_W'(g))  dirty_q[g] <= 1'b1;
        end

        // Hold the most recent byte written to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 buf_q[g] <= 8'h00;
            else if (wr_en_i && wr_sel_i == SEL_W'(g))  buf_q[g] <= wr_data_i;
        end
    end

    assign load_o = frame_end_i & frame_ok_i;
    assign mask_o = dirty_q;
    assign data_o = buf_q;

    // R10: any frame end leaves nothing staged.
    a_r10_frame_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_i |=> (dirty_q == '0));

endmodule

// File: rtl/rtcc_timekeeper.sv
// Live BCD counters with full carry chain and buffered parallel load.
// Assumes tick_i is a one-cycle strobe; a load cycle drops the tick.
module rtcc_timekeeper
    import rtcc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       load_i,
    input  logic [NREG-1:0]            mask_i,
    input  logic [NREG-1:0][7:0]       data_i,
    output logic [NREG-1:0][7:0]       live_o
);

    logic [NREG-1:0][7:0] live_q;
    logic [NREG-1:0][7:0] nxt;
    logic                 tick_eff;

    assign tick_eff = tick_i & ~load_i;

    // Compute the value after one second, rippling carries up the chain.
    always_comb begin
        logic       c_sec, c_min, c_day, c_mon, c_year;
        logic [8:0] hs;
        bcd_t       last;
        nxt    = live_q;
        hs     = hour_step(live_q[IX_HOUR]);
        last   = month_last(live_q[IX_MON], live_q[IX_YEAR]);
        c_sec  = (live_q[IX_SEC] == 8'h59);
        c_min  = c_sec && (live_q[IX_MIN] == 8'h59);
        c_day  = c_min && hs[8];
        c_mon  = c_day && (live_q[IX_DATE] == last);
        c_year = c_mon && (live_q[IX_MON] == 8'h12);
        nxt[IX_SEC] = c_sec ? 8'h00 : bcd_inc(live_q[IX_SEC]);
        if (c_sec) nxt[IX_MIN]  = (live_q[IX_MIN] == 8'h59) ? 8'h00 : bcd_inc(live_q[IX_MIN]);
        if (c_min) nxt[IX_HOUR] = hs[7:0];
        if (c_day) begin
            nxt[IX_DATE] = (live_q[IX_DATE] == last) ? 8'h01 : bcd_inc(live_q[IX_DATE]);
            nxt[IX_DOW]  = (live_q[IX_DOW] == 8'h07) ? 8'h01 : bcd_inc(live_q[IX_DOW]);
        end
        if (c_mon)  nxt[IX_MON]  = (live_q[IX_MON] == 8'h12) ? 8'h01 : bcd_inc(live_q[IX_MON]);
        if (c_year) begin
            nxt[IX_YEAR] = (live_q[IX_YEAR] == 8'h99) ? 8'h00 : bcd_inc(live_q[IX_YEAR]);
            if (live_q[IX_YEAR] == 8'h99)
                nxt[IX_CENT] = (live_q[IX_CENT] == 8'h99) ? 8'h00 : bcd_inc(live_q[IX_CENT]);
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_live
        // Load a staged byte, else advance on an effective tick.
        always_ff @(posedge clk) begin
            if (!rst_n)                    live_q[g] <= time_rst(g);
            else if (load_i && mask_i[g])  live_q[g] <= data_i[g];
            else if (tick_eff)             live_q[g] <= nxt[g];
        end
    end

    assign live_o = live_q;

    // R8: without a tick or a load nothing moves.
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(live_q));

    // R9: a staged seconds byte lands exactly as written.
    a_r9_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && mask_i[IX_SEC]) |=> (live_q[IX_SEC] == $past(data_i[IX_SEC])));

    // R11: an unstaged byte does not advance in a load cycle.
    a_r11_tick_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !mask_i[IX_SEC]) |=> $stable(live_q[IX_SEC]));

    // R3: seconds wrap to zero after 59.
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && live_q[IX_SEC] == 8'h59) |=> (live_q[IX_SEC] == 8'h00));

endmodule

// File: rtl/rtcc_thresholds.sv
// Alarm threshold byte storage with fixed reset values.
// Assumes a select outside the byte range is a no-op.
module rtcc_thresholds
    import rtcc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [TSEL_W-1:0]     sel_i,
    input  logic [7:0]            data_i,
    output logic [NTHR*8-1:0]     thr_o
);

    logic [NTHR-1:0][7:0] thr_q;

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        // Reset to the fixed threshold value, else take a selected write.
        always_ff @(posedge clk) begin
            if (!rst_n)                            thr_q[g] <= thr_rst(g);
            else if (we_i && sel_i == TSEL_W'(g))  thr_q[g] <= data_i;
        end
    end

    assign thr_o = thr_q;

    // R2: thresholds only change on a write.
    a_r2_thr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(thr_q));

endmodule

// File: rtl/rtcc_top.sv
// Buffered BCD clock calendar: shadow staging, live counters, thresholds.
// Assumes frame_end_i is a single-cycle pulse with frame_ok_i valid alongside.
module rtcc_top
    import rtcc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  wr_en_i,
    input  logic [SEL_W-1:0]      wr_sel_i,
    input  logic [7:0]            wr_data_i,
    input  logic                  frame_end_i,
    input  logic                  frame_ok_i,
    input  logic                  thr_we_i,
    input  logic [TSEL_W-1:0]     thr_sel_i,
    input  logic [7:0]            thr_data_i,
    output logic [7:0]            sec_o,
    output logic [7:0]            min_o,
    output logic [7:0]            hour_o,
    output logic [7:0]            date_o,
    output logic [7:0]            month_o,
    output logic [7:0]            dow_o,
    output logic [7:0]            year_o,
    output logic [7:0]            ctrl_o,
    output logic [7:0]            cent_o,
    output logic [NTHR*8-1:0]     thr_o
);

    logic                 load;
    logic [NREG-1:0]      mask;
    logic [NREG-1:0][7:0] sdata;
    logic [NREG-1:0][7:0] live;

    rtcc_shadow u_shadow (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .frame_end_i(frame_end_i), .frame_ok_i(frame_ok_i),
        .load_o(load), .mask_o(mask), .data_o(sdata)
    );

    rtcc_timekeeper u_tk (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .load_i(load), .mask_i(mask), .data_i(sdata), .live_o(live)
    );

    rtcc_thresholds u_thr (
        .clk(clk), .rst_n(rst_n), .we_i(thr_we_i), .sel_i(thr_sel_i),
        .data_i(thr_data_i), .thr_o(thr_o)
    );

    assign sec_o   = live[IX_SEC];
    assign min_o   = live[IX_MIN];
    assign hour_o  = live[IX_HOUR];
    assign date_o  = live[IX_DATE];
    assign month_o = live[IX_MON];
    assign dow_o   = live[IX_DOW];
    assign year_o  = live[IX_YEAR];
    assign ctrl_o  = live[IX_CTRL];
    assign cent_o  = live[IX_CENT];

endmodule

// File: tb/rtcc_top_tb_top.sv
module rtcc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_sel_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic        frame_end_i = 1'b0;
    logic        frame_ok_i = 1'b0;
    logic        thr_we_i = 1'b0;
    logic [2:0]  thr_sel_i = '0;
    logic [7:0]  thr_data_i = '0;
    logic [7:0]  sec_o, min_o, hour_o, date_o, month_o, dow_o, year_o, ctrl_o, cent_o;
    logic [55:0] thr_o;

    always #4 clk = ~clk;   // 125 MHz

    rtcc_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .frame_end_i(frame_end_i), .frame_ok_i(frame_ok_i),
        .thr_we_i(thr_we_i), .thr_sel_i(thr_sel_i), .thr_data_i(thr_data_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
        .month_o(month_o), .dow_o(dow_o), .year_o(year_o), .ctrl_o(ctrl_o),
        .cent_o(cent_o), .thr_o(thr_o)
    );

    typedef struct {
        string       tag;
        logic [71:0] t;
        logic [55:0] a;
    } item_t;

    item_t       sb_q[$];
    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    logic [55:0] exp_thr = 56'hFF_07_1F_3F_BF_7F_7F;

    function automatic logic [71:0] mk(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                                       logic [7:0] d, logic [7:0] mo, logic [7:0] w,
                                       logic [7:0] y, logic [7:0] c, logic [7:0] ce);
        return {ce, c, y, w, mo, d, h, m, s};
    endfunction

    // Monitor: pop each expected item and compare with the outputs.
    initial begin
        forever begin
            item_t it;
            logic [71:0] act;
            wait (sb_q.size() > 0);
            #1;
            it  = sb_q.pop_front();
            act = {cent_o, ctrl_o, year_o, dow_o, month_o, date_o, hour_o, min_o, sec_o};
            total++;
            if (act !== it.t || thr_o !== it.a) begin
                bad++;
                $display("FAIL %s: time act=%h exp=%h thr act=%h exp=%h",
                         it.tag, act, it.t, thr_o, it.a);
            end
        end
    end

    task automatic expect_now(string tag, logic [71:0] t);
        item_t it;
        it.tag = tag; it.t = t; it.a = exp_thr;
        sb_q.push_back(it);
    endtask

    task automatic do_tick();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic shd_wr(logic [3:0] sel, logic [7:0] d);
        @(negedge clk); wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic frame_close(logic ok, logic with_tick);
        @(negedge clk); frame_end_i = 1'b1; frame_ok_i = ok; tick_i = with_tick;
        @(negedge clk); frame_end_i = 1'b0; frame_ok_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic thr_wr(logic [2:0] sel, logic [7:0] d);
        @(negedge clk); thr_we_i = 1'b1; thr_sel_i = sel; thr_data_i = d;
        @(negedge clk); thr_we_i = 1'b0;
    endtask

    task automatic load_all(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d,
                            logic [7:0] mo, logic [7:0] w, logic [7:0] y, logic [7:0] ce);
        shd_wr(4'd0, s);  shd_wr(4'd1, m); shd_wr(4'd2, h); shd_wr(4'd3, d);
        shd_wr(4'd4, mo); shd_wr(4'd5, w); shd_wr(4'd6, y); shd_wr(4'd8, ce);
        frame_close(1'b1, 1'b0);
    endtask

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R1 reset values", mk(8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h70,8'h00,8'h19));

        thr_wr(3'd0, 8'h30);
        exp_thr = 56'hFF_07_1F_3F_BF_7F_30;
        expect_now("R2 threshold write", mk(8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h70,8'h00,8'h19));

        do_tick();
        expect_now("R3 seconds count", mk(8'h01,8'h00,8'h00,8'h01,8'h01,8'h01,8'h70,8'h00,8'h19));

        shd_wr(4'd0, 8'h58); shd_wr(4'd1, 8'h59); shd_wr(4'd2, 8'h23); shd_wr(4'd3, 8'h31);
        shd_wr(4'd4, 8'h12); shd_wr(4'd5, 8'h07); shd_wr(4'd6, 8'h99); shd_wr(4'd8, 8'h19);
        expect_now("R8 staged not live", mk(8'h01,8'h00,8'h00,8'h01,8'h01,8'h01,8'h70,8'h00,8'h19));
        do_tick();
        expect_now("R8 counting while staged", mk(8'h02,8'h00,8'h00,8'h01,8'h01,8'h01,8'h70,8'h00,8'h19));
        frame_close(1'b1, 1'b0);
        expect_now("R9 full commit", mk(8'h58,8'h59,8'h23,8'h31,8'h12,8'h07,8'h99,8'h00,8'h19));
        do_tick();
        do_tick();
        expect_now("R7 century ripple", mk(8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00,8'h00,8'h20));

        shd_wr(4'd0, 8'h45);
        frame_close(1'b0, 1'b0);
        expect_now("R10 abort no change", mk(8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00,8'h00,8'h20));
        frame_close(1'b1, 1'b0);
        expect_now("R10 discarded buffer", mk(8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00,8'h00,8'h20));

        load_all(8'h59,8'h59,8'h23,8'h28,8'h02,8'h03,8'h00,8'h20);
        do_tick();
        expect_now("R6 leap february", mk(8'h00,8'h00,8'h00,8'h29,8'h02,8'h04,8'h00,8'h00,8'h20));
        load_all(8'h59,8'h59,8'h23,8'h28,8'h02,8'h03,8'h01,8'h20);
        do_tick();
        expect_now("R6 plain february", mk(8'h00,8'h00,8'h00,8'h01,8'h03,8'h04,8'h01,8'h00,8'h20));
        load_all(8'h59,8'h59,8'h23,8'h30,8'h04,8'h07,8'h01,8'h20);
        do_tick();
        expect_now("R6 30-day month dow wrap", mk(8'h00,8'h00,8'h00,8'h01,8'h05,8'h01,8'h01,8'h00,8'h20));

        load_all(8'h59,8'h59,8'h19,8'h15,8'h06,8'h02,8'h24,8'h20);
        do_tick();
        expect_now("R4 24h 19 to 20", mk(8'h00,8'h00,8'h20,8'h15,8'h06,8'h02,8'h24,8'h00,8'h20));

        load_all(8'h59,8'h59,8'h91,8'h10,8'h06,8'h02,8'h24,8'h20);
        do_tick();
        expect_now("R5 11AM to 12PM", mk(8'h00,8'h00,8'hB2,8'h10,8'h06,8'h02,8'h24,8'h00,8'h20));
        load_all(8'h59,8'h59,8'hB2,8'h10,8'h06,8'h02,8'h24,8'h20);
        do_tick();
        expect_now("R5 12PM to 1PM", mk(8'h00,8'h00,8'hA1,8'h10,8'h06,8'h02,8'h24,8'h00,8'h20));
        load_all(8'h59,8'h59,8'hB1,8'h10,8'h06,8'h02,8'h24,8'h20);
        do_tick();
        expect_now("R5 11PM to 12AM", mk(8'h00,8'h00,8'h92,8'h11,8'h06,8'h03,8'h24,8'h00,8'h20));

        shd_wr(4'd0, 8'h10);
        frame_close(1'b1, 1'b1);
        expect_now("R11 tick dropped at load", mk(8'h10,8'h00,8'h92,8'h11,8'h06,8'h03,8'h24,8'h00,8'h20));
        do_tick();
        expect_now("R11 next tick advances", mk(8'h11,8'h00,8'h92,8'h11,8'h06,8'h03,8'h24,8'h00,8'h20));

        shd_wr(4'd1, 8'h30); shd_wr(4'd7, 8'h80);
        frame_close(1'b1, 1'b0);
        expect_now("R9 partial commit", mk(8'h11,8'h30,8'h92,8'h11,8'h06,8'h03,8'h24,8'h80,8'h20));

        repeat (4) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule